// File: doc/BRIEF.md
# Asynchronous 16-bit Host Bus Bridge

This block connects a host processor's asynchronous, SRAM-style 16-bit bus to a device core whose register and FIFO paths are 32 bits wide. The host drives an active-low chip select, active-low read and write strobes, a seven-bit half-word address and a FIFO-select line. The bridge brings the strobes into the core clock domain and turns each qualified strobe into a read or write event. It pairs two 16-bit write halves into one 32-bit word, and it splits a 32-bit word across two 16-bit read halves.

Each access goes either to the control/status register space or to the data FIFO port. Writes to the port go to the transmit FIFO and reads from it come from the receive FIFO. The FIFO-select line forces every access to the data port. A byte-order control swaps the bytes of each 16-bit half.

The bridge also ignores host writes until a read has completed after reset or after a power-saving period. A host write cycle seen while power saving is active raises a wake request. The register contents and the FIFO storage sit outside the bridge.

Top module: `hbus_bridge`

## Requirements
- R1: A read or write event happens only while `hb_cs_n` is low together with the strobe. A strobe pulse with `hb_cs_n` high produces no commit, no pop and no change of `hb_rdata`.
- R2: The half is chosen by `hb_addr[0]`. A read with `hb_addr[0]`=0 fetches the full 32-bit word, holds it and returns bits 15:0. A following read with `hb_addr[0]`=1 returns bits 31:16 of the held word.
- R3: A write with `hb_addr[0]`=0 only stores the low half. A write with `hb_addr[0]`=1 commits {this half, stored low half} as one 32-bit word, with a single-cycle `csr_wr` or `tx_push` pulse. A low-half write on its own commits nothing.
- R4: From reset, and for as long as `pwr_save` is high, writes have no effect. Writes take effect only after a read cycle has ended while `pwr_save` is low.
- R5: With `hb_fifo_sel` low and `hb_addr[6:2]` nonzero, the access targets the register space at index `csr_addr` = `hb_addr[6:1]`.
- R6: The data FIFO port is targeted when `hb_fifo_sel` is high, whatever the value of `hb_addr[6:1]`, or when `hb_addr[6:2]` is zero. A committed write there pulses `tx_push` with the word on `tx_wdata` and never pulses `csr_wr`.
- R7: A read of the FIFO port pops the receive FIFO (`rx_pop`, one cycle) only on the high-half read. The two halves therefore come from one FIFO word.
- R8: With `big_end` high, the two bytes of every 16-bit half are exchanged, on writes before assembly and on reads before output.
- R9: A write cycle that starts while `pwr_save` is high raises a one-cycle `wake_req`, whatever the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hb_cs_n | input | 1 | Host chip select, active low, asynchronous |
| hb_rd_n | input | 1 | Host read strobe, active low, asynchronous |
| hb_wr_n | input | 1 | Host write strobe, active low, asynchronous |
| hb_fifo_sel | input | 1 | Forces all accesses to the data FIFO port |
| hb_addr | input | 7 | Half-word address; bit 0 selects the half |
| hb_wdata | input | 16 | Host write data |
| hb_rdata | output | 16 | Host read data, held until the next read |
| big_end | input | 1 | Swap the bytes within each 16-bit half |
| pwr_save | input | 1 | Power-saving state is active |
| wake_req | output | 1 | One-cycle wake request |
| csr_addr | output | 6 | Register index of the current access |
| csr_rdata | input | 32 | Register read word for `csr_addr` |
| csr_wr | output | 1 | Register write commit pulse |
| csr_wdata | output | 32 | Assembled register write word |
| tx_push | output | 1 | Transmit FIFO push pulse |
| tx_wdata | output | 32 | Assembled transmit word |
| rx_rdata | input | 32 | Receive FIFO head word |
| rx_pop | output | 1 | Receive FIFO pop pulse |

## Verification
The wake request and the write lockout act on the same host write cycle. A write issued during power saving must raise `wake_req` and must also commit nothing. To provoke this, the bench issues a full two-half register write while `pwr_save` is high. It judges the result by a wake count that rises by one per write cycle while the register commit count stays unchanged. After `pwr_save` drops, a write must still be refused until a read has ended, and only then is the write accepted.

// File: rtl/hbus_pkg.sv
// Shared widths and helpers for the host bus bridge.
// Assumes the host half-word is two bytes and the core word is two half-words.
package hbus_pkg;
    localparam int HALF_W = 16;
    localparam int WORD_W = 2 * HALF_W;
    localparam int ADDR_W = 7;
    localparam int IDX_W  = ADDR_W - 1;

    // Exchange the two bytes of a half-word
    function automatic logic [HALF_W-1:0] byte_swap(input logic [HALF_W-1:0] v);
        byte_swap = {v[HALF_W/2-1:0], v[HALF_W-1:HALF_W/2]};
    endfunction
endpackage

// File: rtl/hb_sync.sv
// Multi-bit two-stage synchronizer for independent asynchronous levels.
// Assumes each bit is a slow level (host strobes) that idles at 1.
module hb_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] sync_out
);
    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_bit
            logic [STAGES-1:0] chain;
            // Shift the level through the flop chain; reset to idle-high
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], async_in[i]};
            end
            assign sync_out[i] = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/hb_steer.sv
// Address steering: picks the data FIFO port or the register space and
// the half-word select. Assumes bit 0 of the address is the half select.
module hb_steer
    import hbus_pkg::*;
(
    input  logic              fifo_sel,
    input  logic [ADDR_W-1:0] addr,
    output logic              to_fifo,
    output logic              half_hi,
    output logic [IDX_W-1:0]  csr_idx
);
    // FIFO port when forced, or when the upper address field is zero
    always_comb begin
        to_fifo = fifo_sel || (addr[ADDR_W-1:2] == '0);
        half_hi = addr[0];
        csr_idx = addr[ADDR_W-1:1];
    end
endmodule

// File: rtl/hb_pack.sv
// Width conversion: joins write halves into a word and splits read words.
// Assumes rd_start and wr_end are single-cycle events with steering stable.
module hb_pack
    import hbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_start,
    input  logic              wr_end,
    input  logic              wr_ok,
    input  logic              to_fifo,
    input  logic              half_hi,
    input  logic              big_end,
    input  logic [HALF_W-1:0] wdata,
    input  logic [WORD_W-1:0] csr_rdata,
    input  logic [WORD_W-1:0] rx_rdata,
    output logic [HALF_W-1:0] rdata,
    output logic              csr_wr,
    output logic              tx_push,
    output logic [WORD_W-1:0] wword,
    output logic              rx_pop
);
    logic [HALF_W-1:0] wr_lo;
    logic [WORD_W-1:0] rd_hold;
    logic [HALF_W-1:0] win;
    logic [WORD_W-1:0] fetch;

    // Byte-order adjust of the incoming half and selection of the read source
    always_comb begin
        win   = big_end ? byte_swap(wdata) : wdata;
        fetch = to_fifo ? rx_rdata : csr_rdata;
    end

    // Read side: fetch the word on the low half, return halves, pop on high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_hold <= '0;
            rdata   <= '0;
            rx_pop  <= 1'b0;
        end else begin
            rx_pop <= 1'b0;
            if (rd_start) begin
                if (!half_hi) begin
                    rd_hold <= fetch;
                    rdata   <= big_end ? byte_swap(fetch[HALF_W-1:0]) : fetch[HALF_W-1:0];
                end else begin
                    rdata   <= big_end ? byte_swap(rd_hold[WORD_W-1:HALF_W])
                                       : rd_hold[WORD_W-1:HALF_W];
                    rx_pop  <= to_fifo;
                end
            end
        end
    end

    // Write side: store the low half, commit the word on the high half
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_lo   <= '0;
            wword   <= '0;
            csr_wr  <= 1'b0;
            tx_push <= 1'b0;
        end else begin
            csr_wr  <= 1'b0;
            tx_push <= 1'b0;
            if (wr_end && wr_ok) begin
                if (!half_hi) begin
                    wr_lo <= win;
                end else begin
                    wword   <= {win, wr_lo};
                    csr_wr  <= !to_fifo;
                    tx_push <= to_fifo;
                end
            end
        end
    end
endmodule

// File: rtl/hbus_bridge.sv
// Top of the asynchronous host bus bridge. Synchronizes the strobes,
// captures address and data while a qualified strobe is low, derives
// read/write events, enforces the write lockout and raises wake requests.
// Assumes the host holds address and data stable while its strobe is low,
// and keeps each strobe low and each gap high for at least three clocks.
module hbus_bridge
    import hbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hb_cs_n,
    input  logic              hb_rd_n,
    input  logic              hb_wr_n,
    input  logic              hb_fifo_sel,
    input  logic [ADDR_W-1:0] hb_addr,
    input  logic [HALF_W-1:0] hb_wdata,
    output logic [HALF_W-1:0] hb_rdata,
    input  logic              big_end,
    input  logic              pwr_save,
    output logic              wake_req,
    output logic [IDX_W-1:0]  csr_addr,
    input  logic [WORD_W-1:0] csr_rdata,
    output logic              csr_wr,
    output logic [WORD_W-1:0] csr_wdata,
    output logic              tx_push,
    output logic [WORD_W-1:0] tx_wdata,
    input  logic [WORD_W-1:0] rx_rdata,
    output logic              rx_pop
);
    logic [2:0]        strobe_s;
    logic              rd_act, wr_act, rd_prev, wr_prev;
    logic              rd_start, rd_end, wr_start, wr_end;
    logic              locked;
    logic              cap_fsel;
    logic [ADDR_W-1:0] cap_addr;
    logic [HALF_W-1:0] cap_wdata;
    logic              to_fifo, half_hi;
    logic [WORD_W-1:0] wword;

    hb_sync #(.N(3), .STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({hb_wr_n, hb_rd_n, hb_cs_n}),
        .sync_out (strobe_s)
    );

    // Qualified strobes and their edges in the core domain
    always_comb begin
        rd_act   = !strobe_s[0] && !strobe_s[1];
        wr_act   = !strobe_s[0] && !strobe_s[2];
        rd_start = rd_act && !rd_prev;
        rd_end   = !rd_act && rd_prev;
        wr_start = wr_act && !wr_prev;
        wr_end   = !wr_act && wr_prev;
    end

    // Previous qualified strobe levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_prev <= 1'b0;
            wr_prev <= 1'b0;
        end else begin
            rd_prev <= rd_act;
            wr_prev <= wr_act;
        end
    end

    // Capture address, FIFO select and data while a qualified pin strobe is low
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_addr  <= '0;
            cap_fsel  <= 1'b0;
            cap_wdata <= '0;
        end else if (!hb_cs_n && (!hb_rd_n || !hb_wr_n)) begin
            cap_addr  <= hb_addr;
            cap_fsel  <= hb_fifo_sel;
            cap_wdata <= hb_wdata;
        end
    end

    // Write lockout: set by reset and power saving, released by a finished read
    always_ff @(posedge clk) begin
        if (!rst_n)              locked <= 1'b1;
        else if (pwr_save)       locked <= 1'b1;
        else if (rd_end)         locked <= 1'b0;
    end

    // Wake request on any write cycle starting during power saving
    always_ff @(posedge clk) begin
        if (!rst_n) wake_req <= 1'b0;
        else        wake_req <= wr_start && pwr_save;
    end

    hb_steer u_steer (
        .fifo_sel (cap_fsel),
        .addr     (cap_addr),
        .to_fifo  (to_fifo),
        .half_hi  (half_hi),
        .csr_idx  (csr_addr)
    );

    hb_pack u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_start  (rd_start),
        .wr_end    (wr_end),
        .wr_ok     (!locked),
        .to_fifo   (to_fifo),
        .half_hi   (half_hi),
        .big_end   (big_end),
        .wdata     (cap_wdata),
        .csr_rdata (csr_rdata),
        .rx_rdata  (rx_rdata),
        .rdata     (hb_rdata),
        .csr_wr    (csr_wr),
        .tx_push   (tx_push),
        .wword     (wword),
        .rx_pop    (rx_pop)
    );

    assign csr_wdata = wword;
    assign tx_wdata  = wword;
endmodule

// File: rtl/hbus_bridge_chk.sv
// Property checker for the host bus bridge, attached to the top by bind.
// Assumes it observes the top's ports and its internal lockout flag.
module hbus_bridge_chk (
    input logic clk,
    input logic rst_n,
    input logic csr_wr,
    input logic tx_push,
    input logic rx_pop,
    input logic wake_req,
    input logic pwr_save,
    input logic locked
);
    // R3: a commit is a single-cycle pulse
    p_commit_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr || tx_push) |=> !(csr_wr || tx_push));

    // R6: FIFO and register commits never coincide
    p_one_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(csr_wr && tx_push));

    // R4: a commit follows only a cycle in which writes were unlocked
    p_unlocked_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr || tx_push) |-> !$past(locked));

    // R7: one pop per high-half read
    p_pop_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |=> !rx_pop);

    // R9: wake requests only arise during power saving
    p_wake_saving_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> $past(pwr_save));
endmodule

bind hbus_bridge hbus_bridge_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .csr_wr   (csr_wr),
    .tx_push  (tx_push),
    .rx_pop   (rx_pop),
    .wake_req (wake_req),
    .pwr_save (pwr_save),
    .locked   (locked)
);

// File: tb/hbus_bridge_tb_top.sv
// Directed bench for the host bus bridge: one task per scenario.
module hbus_bridge_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD       = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hb_cs_n = 1'b1, hb_rd_n = 1'b1, hb_wr_n = 1'b1, hb_fifo_sel = 1'b0;
    logic [6:0]  hb_addr = '0;
    logic [15:0] hb_wdata = '0;
    logic [15:0] hb_rdata;
    logic        big_end = 1'b0, pwr_save = 1'b0;
    logic        wake_req, csr_wr, tx_push, rx_pop;
    logic [5:0]  csr_addr;
    logic [31:0] csr_rdata, csr_wdata, tx_wdata;
    logic [31:0] rx_head;

    int total = 0, bad = 0;
    int n_csr = 0, n_tx = 0, n_pop = 0, n_wake = 0;
    logic [31:0] last_csr, last_tx;
    logic [5:0]  last_idx;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Register space model: value derived from the index
    function automatic logic [31:0] reg_val(input logic [5:0] idx);
        reg_val = {10'h0, idx, 10'h0, idx} ^ 32'hA5C3_3C5A;
    endfunction
    assign csr_rdata = reg_val(csr_addr);
    assign rx_rdata_w = rx_head;
    logic [31:0] rx_rdata_w;

    hbus_bridge dut_i (
        .clk(clk), .rst_n(rst_n), .hb_cs_n(hb_cs_n), .hb_rd_n(hb_rd_n),
        .hb_wr_n(hb_wr_n), .hb_fifo_sel(hb_fifo_sel), .hb_addr(hb_addr),
        .hb_wdata(hb_wdata), .hb_rdata(hb_rdata), .big_end(big_end),
        .pwr_save(pwr_save), .wake_req(wake_req), .csr_addr(csr_addr),
        .csr_rdata(csr_rdata), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
        .tx_push(tx_push), .tx_wdata(tx_wdata), .rx_rdata(rx_rdata_w),
        .rx_pop(rx_pop)
    );

    // Event log of the core-side pulses and the receive FIFO model
    always @(posedge clk) begin
        if (!rst_n) rx_head <= 32'h1111_2222;
        else begin
            if (csr_wr)   begin n_csr++; last_csr = csr_wdata; last_idx = csr_addr; end
            if (tx_push)  begin n_tx++;  last_tx  = tx_wdata; end
            if (wake_req) n_wake++;
            if (rx_pop)   begin n_pop++; rx_head <= rx_head + 32'h0101_0101; end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] sw(input logic [15:0] v);
        sw = {v[7:0], v[15:8]};
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One host cycle; cs_on=0 leaves chip select high
    task automatic host_cycle(input bit wr, input bit cs_on, input bit fsel,
                              input logic [6:0] a, input logic [15:0] d,
                              output logic [15:0] q);
        @(negedge clk);
        hb_addr = a; hb_fifo_sel = fsel; hb_wdata = d;
        wait_clk(1);
        hb_cs_n = !cs_on;
        if (wr) hb_wr_n = 1'b0; else hb_rd_n = 1'b0;
        wait_clk(HOLD);
        q = hb_rdata;
        hb_cs_n = 1'b1; hb_rd_n = 1'b1; hb_wr_n = 1'b1;
        wait_clk(HOLD);
    endtask

    task automatic hwrite(input bit fsel, input logic [6:0] a, input logic [15:0] d);
        logic [15:0] q;
        host_cycle(1'b1, 1'b1, fsel, a, d, q);
    endtask

    task automatic hread(input bit fsel, input logic [6:0] a, output logic [15:0] q);
        host_cycle(1'b0, 1'b1, fsel, a, 16'h0, q);
    endtask

    task automatic t_reset;
        check("R3 reset csr_wr", {31'b0, csr_wr}, 32'h0);
        check("R7 reset rx_pop", {31'b0, rx_pop}, 32'h0);
        check("R2 reset rdata", {16'h0, hb_rdata}, 32'h0);
    endtask

    task automatic t_locked_from_reset;
        hwrite(1'b0, 7'h20, 16'h1234);
        hwrite(1'b0, 7'h21, 16'h5678);
        check("R4 write before first read ignored", n_csr, 0);
    endtask

    task automatic t_csr_read;
        logic [15:0] q;
        logic [31:0] v = reg_val(6'h08);
        hread(1'b0, 7'h10, q);
        check("R2 R5 low half", {16'h0, q}, {16'h0, v[15:0]});
        hread(1'b0, 7'h11, q);
        check("R2 R5 high half", {16'h0, q}, {16'h0, v[31:16]});
        check("R7 no pop for register read", n_pop, 0);
    endtask

    task automatic t_csr_write;
        hwrite(1'b0, 7'h2A, 16'hBEEF);
        check("R3 low half alone commits nothing", n_csr, 0);
        hwrite(1'b0, 7'h2B, 16'hCAFE);
        check("R3 one register commit", n_csr, 1);
        check("R3 assembled word", last_csr, 32'hCAFE_BEEF);
        check("R5 register index", {26'h0, last_idx}, 32'h15);
        check("R6 no fifo push for register", n_tx, 0);
    endtask

    task automatic t_fifo_write;
        hwrite(1'b1, 7'h7C, 16'h0A0B);
        hwrite(1'b1, 7'h55, 16'h0C0D);
        check("R6 forced fifo push", n_tx, 1);
        check("R6 forced fifo word", last_tx, 32'h0C0D_0A0B);
        check("R6 no register commit", n_csr, 1);
        hwrite(1'b0, 7'h02, 16'h1357);
        hwrite(1'b0, 7'h03, 16'h2468);
        check("R6 window fifo push", n_tx, 2);
        check("R6 window fifo word", last_tx, 32'h2468_1357);
    endtask

    task automatic t_fifo_read;
        logic [15:0] q;
        logic [31:0] w = rx_head;
        hread(1'b1, 7'h7E, q);
        check("R7 low half fifo data", {16'h0, q}, {16'h0, w[15:0]});
        check("R7 no pop on low half", n_pop, 0);
        hread(1'b1, 7'h41, q);
        check("R7 high half same word", {16'h0, q}, {16'h0, w[31:16]});
        check("R7 one pop after high half", n_pop, 1);
        check("R7 fifo advanced", rx_head, w + 32'h0101_0101);
    endtask

    task automatic t_big_endian;
        logic [15:0] q;
        logic [31:0] v = reg_val(6'h0C);
        big_end = 1'b1;
        hwrite(1'b0, 7'h30, 16'h1122);
        hwrite(1'b0, 7'h31, 16'h3344);
        check("R8 swapped write word", last_csr, 32'h4433_2211);
        hread(1'b0, 7'h18, q);
        check("R8 swapped low read", {16'h0, q}, {16'h0, sw(v[15:0])});
        hread(1'b0, 7'h19, q);
        check("R8 swapped high read", {16'h0, q}, {16'h0, sw(v[31:16])});
        big_end = 1'b0;
    endtask

    task automatic t_power_save;
        logic [15:0] q;
        int c0 = n_csr;
        int w0 = n_wake;
        pwr_save = 1'b1;
        wait_clk(2);
        hwrite(1'b0, 7'h24, 16'hAAAA);
        hwrite(1'b0, 7'h25, 16'hBBBB);
        check("R9 wake per write cycle", n_wake, w0 + 2);
        check("R4 no commit in power save", n_csr, c0);
        pwr_save = 1'b0;
        wait_clk(2);
        hwrite(1'b0, 7'h24, 16'hCCCC);
        hwrite(1'b0, 7'h25, 16'hDDDD);
        check("R4 still locked after power save", n_csr, c0);
        check("R9 no wake outside power save", n_wake, w0 + 2);
        hread(1'b0, 7'h10, q);
        hwrite(1'b0, 7'h24, 16'hEEEE);
        hwrite(1'b0, 7'h25, 16'hFFFF);
        check("R4 unlocked after read", n_csr, c0 + 1);
        check("R4 word after unlock", last_csr, 32'hFFFF_EEEE);
    endtask

    task automatic t_no_chip_select;
        logic [15:0] q0, q;
        int c0 = n_csr;
        int p0 = n_pop;
        q0 = hb_rdata;
        host_cycle(1'b1, 1'b0, 1'b0, 7'h24, 16'h0101, q);
        host_cycle(1'b1, 1'b0, 1'b0, 7'h25, 16'h0202, q);
        check("R1 write without select ignored", n_csr, c0);
        host_cycle(1'b0, 1'b0, 1'b1, 7'h01, 16'h0, q);
        check("R1 read without select keeps rdata", {16'h0, hb_rdata}, {16'h0, q0});
        check("R1 read without select no pop", n_pop, p0);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(2);
        t_reset();
        t_locked_from_reset();
        t_csr_read();
        t_csr_write();
        t_fifo_write();
        t_fifo_read();
        t_big_endian();
        t_power_save();
        t_no_chip_select();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule